// File: doc/BRIEF.md
# Counted Sample Capture Gate

The gate sits between a free-running stream of 16-bit converter samples and a streaming write channel of a DMA engine. While idle it discards every sample. Software arms it by writing a control word whose enable bit goes from 0 to 1. The same word carries a beat count. After arming, the gate packs incoming samples four to a 64-bit beat and hands exactly the requested number of beats downstream over a valid/ready handshake. It marks the final beat and then returns to idle.

The converter stream cannot be stalled. If a packed word is complete while the previous beat is still waiting for acceptance, the new word is lost. A sticky overflow flag records this loss. If the consumer waits for data for too long during a capture, a sticky underflow flag records that. A status word reports both flags along with a busy flag, and a read strobe on that word clears the sticky flags.

Top module: `cap_gate`

## Requirements
- R1: After a synchronous active-low reset, status bits busy (bit 0), overflow (bit 1) and underflow (bit 2) are 0 and `m_valid` is 0.
- R2: A control write with enable (bit 16 of `ctrl_wdata`) at 1 starts a capture, with busy set in the following cycle, only if the previous control write left enable at 0. A write of enable 1 over an existing enable of 1 starts nothing.
- R3: A count field value N (bits 15:0 of the arming write) yields exactly N+1 beats. After the last beat no further beat is offered, even while samples keep arriving.
- R4: Each beat holds four consecutive accepted samples, with the oldest in bits 15:0 and the newest in bits 63:48.
- R5: `m_last` is high only on the final beat of a capture. Busy falls on the clock edge at which that beat is accepted.
- R6: While `m_valid` is high and `m_ready` is low, `m_data` and `m_last` stay unchanged and `m_valid` stays high.
- R7: A packed word that completes while the held beat is unaccepted is dropped. Overflow (status bit 1) is set, and the beat counter does not advance.
- R8: During a capture, once `m_ready` has been high with no beat offered for more than UNF_LIMIT consecutive cycles, underflow (status bit 2) is set. After exactly UNF_LIMIT such cycles it is still clear.
- R9: Overflow and underflow stay set until a cycle with `stat_rd` high clears them. A new event in the same cycle wins over the clear.
- R10: An arming edge (enable written to 0 and then back to 1) during a running capture is ignored. The running capture keeps its original count.
- R11: Samples that arrive while the gate is idle are not packed. The first beat of a capture starts with the first sample after arming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_valid | input | 1 | Sample present this cycle |
| s_data | input | 16 | Sample value |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 17 | Control word: bit 16 enable, bits 15:0 beat count minus one |
| stat_rd | input | 1 | Status read strobe, clears the sticky flags |
| status_rdata | output | 3 | Bit 0 busy, bit 1 overflow, bit 2 underflow |
| m_valid | output | 1 | Beat offered downstream |
| m_data | output | 64 | Packed beat, four samples |
| m_last | output | 1 | Final beat of the capture |
| m_ready | input | 1 | Downstream accepts the beat |

## Verification
The bench checks the one-beat capture and a capture that runs past the requested length. A design with an off-by-one in the count would send one beat too many or too few, or mark the wrong beat as last. It stalls the consumer across three packed words. A design that overwrote the held beat, or that counted a dropped word, would deliver the wrong second beat or end early. It probes the underflow window one cycle on each side of the limit. It also re-arms both without a fresh 0-to-1 edge and in the middle of a capture, where a level-sensitive or restartable arm would start or restart a capture. It feeds samples while idle, which a packer that always runs would leak into the first beat.

// File: rtl/cap_gate_pkg.sv
// Shared constants for the counted sample capture gate.
// Assumes: status bit positions are decoded by the register slave beside it.
package cap_gate_pkg;
    localparam int STAT_BUSY = 0;
    localparam int STAT_OVF  = 1;
    localparam int STAT_UNF  = 2;
    localparam int STAT_W    = 3;
endpackage

// File: rtl/cgate_ctrl.sv
// Control word capture: remembers the last written enable level and emits a
// one-cycle arm pulse with the count on a 0-to-1 transition of enable.
// Assumes: ctrl_we is a single-cycle strobe from the register slave.
module cgate_ctrl #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_we,
    input  logic [CNT_W:0]   ctrl_wdata,
    output logic             arm,
    output logic [CNT_W-1:0] arm_count
);
    localparam int EN_BIT = CNT_W;

    logic en_q;

    // Holds the enable level of the most recent control write.
    always_ff @(posedge clk) begin
        if (!rst_n)       en_q <= 1'b0;
        else if (ctrl_we) en_q <= ctrl_wdata[EN_BIT];
    end

    // Arm on a write that raises enable from 0 to 1.
    always_comb begin
        arm       = ctrl_we && ctrl_wdata[EN_BIT] && !en_q;
        arm_count = ctrl_wdata[CNT_W-1:0];
    end
endmodule

// File: rtl/cgate_packer.sv
// Sample packer: gathers LANES samples into one word, oldest in the low lane,
// and pulses w_valid for one cycle when a word is complete.
// Assumes: start restarts lane filling; samples are taken only while run is high.
module cgate_packer #(
    parameter int SAMPLE_W = 16,
    parameter int LANES    = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic                      run,
    input  logic                      s_valid,
    input  logic [SAMPLE_W-1:0]       s_data,
    output logic                      w_valid,
    output logic [SAMPLE_W*LANES-1:0] w_data
);
    localparam int WORD_W = SAMPLE_W * LANES;
    localparam int IDX_W  = (LANES > 1) ? $clog2(LANES) : 1;
    localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(LANES - 1);

    logic [IDX_W-1:0]    idx;
    logic [WORD_W-1:0]   word_c;
    logic                take;

    assign take = run && s_valid && !start;

    // The newest sample closes the word directly from the input.
    assign word_c[WORD_W-1 -: SAMPLE_W] = s_data;

    genvar g;
    generate
        for (g = 0; g < LANES - 1; g++) begin : g_lane
            logic [SAMPLE_W-1:0] lane_q;
            // Stores the sample for lane g while the word is being filled.
            always_ff @(posedge clk) begin
                if (!rst_n)                          lane_q <= '0;
                else if (take && idx == IDX_W'(g))   lane_q <= s_data;
            end
            assign word_c[g*SAMPLE_W +: SAMPLE_W] = lane_q;
        end
    endgenerate

    // Tracks the lane to fill and publishes a finished word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx     <= '0;
            w_valid <= 1'b0;
            w_data  <= '0;
        end else begin
            w_valid <= 1'b0;
            if (start) begin
                idx <= '0;
            end else if (take) begin
                if (idx == IDX_TOP) begin
                    idx     <= '0;
                    w_valid <= 1'b1;
                    w_data  <= word_c;
                end else begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/cgate_beat_out.sv
// Beat output stage: holds one beat for the valid/ready handshake, counts
// loaded beats against the programmed length, flags the last beat and drops
// words that arrive while the held beat is still waiting.
// Assumes: start is only asserted while idle.
module cgate_beat_out #(
    parameter int WORD_W = 64,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  start_count,
    input  logic              w_valid,
    input  logic [WORD_W-1:0] w_data,
    input  logic              m_ready,
    output logic              m_valid,
    output logic [WORD_W-1:0] m_data,
    output logic              m_last,
    output logic              busy,
    output logic              run,
    output logic              drop
);
    logic [CNT_W-1:0] target_q;
    logic [CNT_W-1:0] loaded_q;
    logic             last_loaded_q;
    logic             slot_free;
    logic             load;
    logic             is_final;

    always_comb begin
        run       = busy && !last_loaded_q;
        slot_free = !m_valid || m_ready;
        load      = run && w_valid && slot_free;
        drop      = run && w_valid && !slot_free;
        is_final  = (loaded_q == target_q);
    end

    // Capture state, beat counter and the held output beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy          <= 1'b0;
            target_q      <= '0;
            loaded_q      <= '0;
            last_loaded_q <= 1'b0;
            m_valid       <= 1'b0;
            m_data        <= '0;
            m_last        <= 1'b0;
        end else if (start) begin
            busy          <= 1'b1;
            target_q      <= start_count;
            loaded_q      <= '0;
            last_loaded_q <= 1'b0;
        end else begin
            if (m_valid && m_ready) begin
                m_valid <= 1'b0;
                m_last  <= 1'b0;
                if (m_last) busy <= 1'b0;
            end
            if (load) begin
                m_valid  <= 1'b1;
                m_data   <= w_data;
                m_last   <= is_final;
                loaded_q <= loaded_q + 1'b1;
                if (is_final) last_loaded_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/cgate_starve.sv
// Starvation watch: counts consecutive capture cycles in which the consumer
// is ready but no beat is offered, and pulses once the run exceeds LIMIT.
// Assumes: LIMIT >= 1.
module cgate_starve #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  logic m_ready,
    input  logic m_valid,
    output logic starve
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] run_q;
    logic          waiting;

    assign waiting = busy && m_ready && !m_valid;
    assign starve  = waiting && (run_q == LIM);

    // Saturating count of the current waiting run.
    always_ff @(posedge clk) begin
        if (!rst_n || !waiting) run_q <= '0;
        else if (run_q != LIM)  run_q <= run_q + 1'b1;
    end
endmodule

// File: rtl/cap_gate.sv
// Counted sample capture gate top: arms on an enable edge, packs samples into
// beats, forwards the programmed number of beats and keeps sticky loss flags.
// Assumes: the sample stream cannot be stalled; the register slave decodes
// the control and status words.
module cap_gate #(
    parameter int SAMPLE_W  = 16,
    parameter int LANES     = 4,
    parameter int CNT_W     = 16,
    parameter int UNF_LIMIT = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         s_valid,
    input  logic [SAMPLE_W-1:0]          s_data,
    input  logic                         ctrl_we,
    input  logic [CNT_W:0]               ctrl_wdata,
    input  logic                         stat_rd,
    output logic [cap_gate_pkg::STAT_W-1:0] status_rdata,
    output logic                         m_valid,
    output logic [SAMPLE_W*LANES-1:0]    m_data,
    output logic                         m_last,
    input  logic                         m_ready
);
    import cap_gate_pkg::*;

    localparam int WORD_W = SAMPLE_W * LANES;

    logic              arm;
    logic [CNT_W-1:0]  arm_count;
    logic              start;
    logic              busy;
    logic              run;
    logic              drop;
    logic              starve;
    logic              w_valid;
    logic [WORD_W-1:0] w_data;
    logic              ovf_q;
    logic              unf_q;

    assign start = arm && !busy;

    cgate_ctrl #(.CNT_W(CNT_W)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .arm(arm), .arm_count(arm_count)
    );

    cgate_packer #(.SAMPLE_W(SAMPLE_W), .LANES(LANES)) pack_i (
        .clk(clk), .rst_n(rst_n), .start(start), .run(run),
        .s_valid(s_valid), .s_data(s_data), .w_valid(w_valid), .w_data(w_data)
    );

    cgate_beat_out #(.WORD_W(WORD_W), .CNT_W(CNT_W)) out_i (
        .clk(clk), .rst_n(rst_n), .start(start), .start_count(arm_count),
        .w_valid(w_valid), .w_data(w_data), .m_ready(m_ready),
        .m_valid(m_valid), .m_data(m_data), .m_last(m_last),
        .busy(busy), .run(run), .drop(drop)
    );

    cgate_starve #(.LIMIT(UNF_LIMIT)) starve_i (
        .clk(clk), .rst_n(rst_n), .busy(busy), .m_ready(m_ready),
        .m_valid(m_valid), .starve(starve)
    );

    // Sticky loss flags: a new event wins over a clear by status read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
            unf_q <= 1'b0;
        end else begin
            ovf_q <= drop   || (ovf_q && !stat_rd);
            unf_q <= starve || (unf_q && !stat_rd);
        end
    end

    // Status word assembly.
    always_comb begin
        status_rdata            = '0;
        status_rdata[STAT_BUSY] = busy;
        status_rdata[STAT_OVF]  = ovf_q;
        status_rdata[STAT_UNF]  = unf_q;
    end
endmodule

// File: rtl/cap_gate_chk.sv
// Port-level protocol checker for cap_gate, attached by bind.
// Assumes: status bit 0 busy, bit 1 overflow; enable is the top control bit.
module cap_gate_chk #(
    parameter int WORD_W = 64,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ctrl_we,
    input logic [CNT_W:0]    ctrl_wdata,
    input logic              stat_rd,
    input logic [2:0]        status_rdata,
    input logic              m_valid,
    input logic [WORD_W-1:0] m_data,
    input logic              m_last,
    input logic              m_ready
);
    // R6
    hold_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid && !m_ready |=> m_valid && $stable(m_data) && $stable(m_last));
    // R5
    last_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid && m_ready && m_last |=> !status_rdata[0]);
    // R5
    last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_last |-> m_valid);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !status_rdata[0] |-> !m_valid);
    // R2
    arm_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_rdata[0]) |-> $past(ctrl_we && ctrl_wdata[CNT_W]));
    // R9
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_rdata[1] && !stat_rd |=> status_rdata[1]);
endmodule

bind cap_gate cap_gate_chk #(.WORD_W(SAMPLE_W*LANES), .CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .stat_rd(stat_rd), .status_rdata(status_rdata), .m_valid(m_valid),
    .m_data(m_data), .m_last(m_last), .m_ready(m_ready)
);

// File: tb/cap_gate_tb_top.sv
module cap_gate_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int UNF_LIM    = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        s_valid = 1'b0;
    logic [15:0] s_data = '0;
    logic        ctrl_we = 1'b0;
    logic [16:0] ctrl_wdata = '0;
    logic        stat_rd = 1'b0;
    logic [2:0]  status_rdata;
    logic        m_valid;
    logic [63:0] m_data;
    logic        m_last;
    logic        m_ready = 1'b0;

    int checks = 0;
    int errors = 0;
    int rx_n = 0;
    logic [63:0] rx_data [0:31];
    logic        rx_last [0:31];

    always #(CLK_PERIOD/2) clk = ~clk;

    cap_gate #(.UNF_LIMIT(UNF_LIM)) dut_i (
        .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_data(s_data),
        .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .stat_rd(stat_rd),
        .status_rdata(status_rdata), .m_valid(m_valid), .m_data(m_data),
        .m_last(m_last), .m_ready(m_ready)
    );

    // Records each accepted beat, sampled mid-cycle.
    always @(negedge clk) begin
        if (rst_n && m_valid && m_ready && rx_n < 32) begin
            rx_data[rx_n] = m_data;
            rx_last[rx_n] = m_last;
            rx_n++;
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] beat(input logic [15:0] b);
        return {b + 16'd3, b + 16'd2, b + 16'd1, b};
    endfunction

    task automatic write_ctrl(input logic en, input logic [15:0] cnt);
        ctrl_we = 1'b1; ctrl_wdata = {en, cnt};
        tick();
        ctrl_we = 1'b0;
    endtask

    task automatic feed(input int n, input logic [15:0] base, input bit gap);
        for (int i = 0; i < n; i++) begin
            s_valid = 1'b1; s_data = base + 16'(i);
            tick();
            if (gap) begin s_valid = 1'b0; tick(); end
        end
        s_valid = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 200 && status_rdata[0]; i++) tick();
        repeat (3) tick();
    endtask

    task automatic clear_status();
        stat_rd = 1'b1; tick(); stat_rd = 1'b0;
    endtask

    task automatic test_reset();
        chk("R1 status after reset", 64'(status_rdata), 64'd0);
        chk("R1 m_valid after reset", 64'(m_valid), 64'd0);
    endtask

    task automatic test_basic();
        m_ready = 1'b1; rx_n = 0;
        write_ctrl(1'b0, 16'd0);
        write_ctrl(1'b1, 16'd2);
        chk("R2 busy after arm", 64'(status_rdata[0]), 64'd1);
        feed(12, 16'h0100, 1'b0);
        wait_idle();
        chk("R3 beat count N=2", 64'(rx_n), 64'd3);
        for (int k = 0; k < 3; k++) begin
            chk("R4 packing order", rx_data[k], beat(16'h0100 + 16'(4*k)));
            chk("R5 last marker", 64'(rx_last[k]), 64'(k == 2));
        end
        chk("R5 busy low after last", 64'(status_rdata[0]), 64'd0);
        feed(8, 16'h0900, 1'b0);
        repeat (4) tick();
        chk("R3 no beats after end", 64'(rx_n), 64'd3);
        chk("R8 no flags on clean run", 64'(status_rdata[2:1]), 64'd0);
    endtask

    task automatic test_single_idle_samples();
        m_ready = 1'b1; rx_n = 0;
        write_ctrl(1'b0, 16'd0);
        feed(3, 16'hAA00, 1'b0);
        write_ctrl(1'b1, 16'd0);
        feed(4, 16'h3000, 1'b1);
        wait_idle();
        chk("R3 single beat", 64'(rx_n), 64'd1);
        chk("R11 idle samples ignored", rx_data[0], beat(16'h3000));
        chk("R5 single beat is last", 64'(rx_last[0]), 64'd1);
    endtask

    task automatic test_overflow();
        rx_n = 0; m_ready = 1'b0;
        write_ctrl(1'b0, 16'd0);
        clear_status();
        write_ctrl(1'b1, 16'd1);
        feed(12, 16'h4000, 1'b0);
        repeat (2) tick();
        chk("R7 overflow flag", 64'(status_rdata[1]), 64'd1);
        chk("R6 held valid", 64'(m_valid), 64'd1);
        chk("R6 held data", m_data, beat(16'h4000));
        repeat (3) tick();
        chk("R6 data stable under stall", m_data, beat(16'h4000));
        m_ready = 1'b1;
        feed(4, 16'h4100, 1'b0);
        wait_idle();
        chk("R7 two beats delivered", 64'(rx_n), 64'd2);
        chk("R7 first beat kept", rx_data[0], beat(16'h4000));
        chk("R7 counter not advanced by drop", rx_data[1], beat(16'h4100));
        chk("R9 overflow sticky", 64'(status_rdata[1]), 64'd1);
        clear_status();
        chk("R9 overflow cleared by read", 64'(status_rdata[1]), 64'd0);
    endtask

    task automatic test_underflow();
        rx_n = 0; m_ready = 1'b1;
        write_ctrl(1'b0, 16'd0);
        clear_status();
        write_ctrl(1'b1, 16'd0);
        repeat (UNF_LIM) tick();
        chk("R8 clear at limit", 64'(status_rdata[2]), 64'd0);
        tick();
        chk("R8 set past limit", 64'(status_rdata[2]), 64'd1);
        feed(4, 16'h5000, 1'b0);
        wait_idle();
        chk("R9 underflow sticky", 64'(status_rdata[2]), 64'd1);
        clear_status();
        chk("R9 underflow cleared by read", 64'(status_rdata[2]), 64'd0);
    endtask

    task automatic test_rearm();
        m_ready = 1'b1; rx_n = 0;
        write_ctrl(1'b1, 16'd0);
        chk("R2 no arm without edge", 64'(status_rdata[0]), 64'd0);
        write_ctrl(1'b0, 16'd0);
        write_ctrl(1'b1, 16'd1);
        write_ctrl(1'b0, 16'd0);
        write_ctrl(1'b1, 16'd0);
        chk("R10 still busy", 64'(status_rdata[0]), 64'd1);
        feed(12, 16'h6000, 1'b0);
        wait_idle();
        chk("R10 original count kept", 64'(rx_n), 64'd2);
        chk("R10 second beat data", rx_data[1], beat(16'h6004));
    endtask

    initial begin
        fork
            begin
                repeat (3) tick();
                rst_n = 1'b1;
                tick();
                test_reset();
                test_basic();
                test_single_idle_samples();
                test_overflow();
                test_underflow();
                test_rearm();
            end
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule